// File: doc/BRIEF.md
# DRAM Rank Address Decoder

This block turns a 33-bit physical address into the DRAM channel and rank that hold it. Software programs the memory layout through two sets of per-channel registers. One set holds rank boundaries that accumulate from rank to rank, in 32 MiB units. The other holds 3-bit page-size codes, one for each rank. The decoder compares the two channels' programming on every cycle. When the two channels match exactly, it treats them as a symmetric interleaved pair. Otherwise it stacks channel 1 above channel 0 as an asymmetric layout.

A request is an address qualified by a valid strobe. One clock later the block reports the selected rank, the channel, whether the address falls outside populated memory, and whether the interleaved layout was in force, all marked by a response valid. Addresses that land in an empty or unpopulated span are reported as out of range. The register stage holds its last result while no request is presented.

Top module: `rank_addr_decoder`

## Requirements
- R1: The address unit is address bits 32:25 (32 MiB granules). Rank i of a channel spans units from boundary[i-1] (zero for rank 0) up to but not including boundary[i]. Boundary byte i sits at bits 8i+7:8i of the channel's boundary bus. When several ranks qualify, the lowest-numbered one is reported.
- R2: A rank whose boundary equals the previous boundary covers no units and is never reported.
- R3: The page code of rank i sits at bits 4i+2:4i of the channel's attribute bus. Even ranks therefore use bits 2:0 of a byte and odd ranks use bits 6:4. Codes 3'b010, 3'b011 and 3'b100 mean populated. Code 3'b000 and the reserved codes (3'b001, 3'b101, 3'b110, 3'b111) mean unpopulated. An address inside an unpopulated rank's span is out of range.
- R4: rsp_ilv is 1 exactly when all four boundary bytes and all four 3-bit page codes agree between the channels. Attribute bits 4i+3 play no part in this comparison.
- R5: In interleaved mode, rank i's boundary is twice the channel 0 byte, and rsp_chan equals address bit 6.
- R6: In asymmetric mode, channel 0 (rsp_chan=0) covers units below channel 0's boundary[3]. Units at or above that value go to channel 1 (rsp_chan=1), whose rank i ends at channel-0 boundary[3] plus channel-1 boundary[i].
- R7: rsp_oor is 1 for units at or above the total: twice channel-0 boundary[3] when interleaved, otherwise the sum of both boundary[3] bytes. rsp_rank is 0 whenever rsp_oor is 1.
- R8: Results appear one cycle after req_valid, with rsp_valid equal to req_valid delayed by one cycle. Without req_valid, rsp_rank, rsp_chan, rsp_oor and rsp_ilv keep their values.
- R9: A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_ch0 | input | 32 | Channel 0 cumulative rank boundaries, byte per rank |
| bnd_ch1 | input | 32 | Channel 1 cumulative rank boundaries, byte per rank |
| attr_ch0 | input | 16 | Channel 0 page codes, nibble per rank |
| attr_ch1 | input | 16 | Channel 1 page codes, nibble per rank |
| req_valid | input | 1 | Address request strobe |
| req_addr | input | 33 | Physical address |
| rsp_valid | output | 1 | Result valid |
| rsp_rank | output | 2 | Selected rank within the channel |
| rsp_chan | output | 1 | Selected channel |
| rsp_oor | output | 1 | Address outside populated memory |
| rsp_ilv | output | 1 | Interleaved layout in force |

## Verification
The hardest case to reach is interleaved mode itself. It needs eight page codes and eight boundary bytes to match exactly, and independent random programming almost never produces that. The stimulus therefore copies channel 0's programming into channel 1 for half of the random layouts. It then randomises only the ignored nibble bits 3, so those bits cannot break symmetry. Directed layouts cover the remaining cases: an empty rank, a reserved code, and a single-field mismatch. Addresses are drawn up to a few granules past the total, so the out-of-range edge is crossed repeatedly.

// File: rtl/rank_addr_pkg.sv
// Shared constants and page-code helpers for the rank address decoder.
// Assumes 3-bit page codes packed one per 4-bit nibble.
package rank_addr_pkg;
    localparam int DEF_RANKS      = 4;
    localparam int DEF_BND_W      = 8;
    localparam int DEF_ADDR_W     = 33;
    localparam int DEF_UNIT_SHIFT = 25;
    localparam int DEF_ILV_BIT    = 6;
    localparam int CODE_W         = 3;
    localparam int NIB_W          = 4;

    typedef enum logic [CODE_W-1:0] {
        PAGE_NONE = 3'b000,
        PAGE_4K   = 3'b010,
        PAGE_8K   = 3'b011,
        PAGE_16K  = 3'b100
    } page_code_e;

    // True only for the three legal page sizes; reserved codes count as empty.
    function automatic logic code_populated(input logic [CODE_W-1:0] c);
        return (c == PAGE_4K) || (c == PAGE_8K) || (c == PAGE_16K);
    endfunction
endpackage

// File: rtl/rank_mode_detect.sv
// Decides whether the two channels are programmed identically (interleaved).
// Assumes page codes sit in the low 3 bits of each rank nibble; the top
// nibble bit is reserved and ignored.
module rank_mode_detect
    import rank_addr_pkg::*;
#(
    parameter int RANKS = DEF_RANKS,
    parameter int BND_W = DEF_BND_W
) (
    input  logic [RANKS*BND_W-1:0] bnd0,
    input  logic [RANKS*BND_W-1:0] bnd1,
    input  logic [RANKS*NIB_W-1:0] attr0,
    input  logic [RANKS*NIB_W-1:0] attr1,
    output logic                   interleaved
);
    logic [RANKS-1:0] code_eq;

    // Per-rank page code comparison.
    for (genvar r = 0; r < RANKS; r++) begin : g_code
        assign code_eq[r] = (attr0[r*NIB_W +: CODE_W] == attr1[r*NIB_W +: CODE_W]);
    end

    // Symmetric only if every boundary and every code matches.
    assign interleaved = (bnd0 == bnd1) && (&code_eq);

    logic unused_rsv;
    assign unused_rsv = ^{attr0, attr1};
endmodule

// File: rtl/rank_bound_search.sv
// Finds the lowest rank whose limit exceeds the address unit.
// Assumes limits are cumulative; an empty rank (equal limits) can never be
// the lowest match.
module rank_bound_search #(
    parameter int RANKS  = 4,
    parameter int CMP_W  = 10,
    parameter int UNIT_W = 8,
    localparam int RIDX_W = $clog2(RANKS)
) (
    input  logic [RANKS*CMP_W-1:0] limits,
    input  logic [UNIT_W-1:0]      unit,
    output logic                   hit,
    output logic [RIDX_W-1:0]      idx
);
    logic [RANKS-1:0] below;

    // One comparator per rank limit.
    for (genvar r = 0; r < RANKS; r++) begin : g_cmp
        assign below[r] = CMP_W'(unit) < limits[r*CMP_W +: CMP_W];
    end

    // Priority pick of the lowest qualifying rank.
    always_comb begin
        hit = |below;
        idx = '0;
        for (int r = RANKS - 1; r >= 0; r--) begin
            if (below[r]) idx = RIDX_W'(r);
        end
    end
endmodule

// File: rtl/rank_code_fetch.sv
// Returns whether the rank at a given index carries a legal page code.
// Assumes one nibble per rank, code in the nibble's low 3 bits.
module rank_code_fetch
    import rank_addr_pkg::*;
#(
    parameter int RANKS = DEF_RANKS,
    localparam int RIDX_W = $clog2(RANKS)
) (
    input  logic [RANKS*NIB_W-1:0] attr,
    input  logic [RIDX_W-1:0]      idx,
    output logic                   populated
);
    logic [CODE_W-1:0] code;

    // Select the indexed nibble and classify its code.
    always_comb begin
        code      = attr[idx*NIB_W +: CODE_W];
        populated = code_populated(code);
    end
endmodule

// File: rtl/rank_addr_decoder.sv
// Maps a physical address to channel and rank from cumulative per-channel
// rank boundaries and per-rank page codes. Chooses interleaved mapping when
// both channels match, stacked mapping otherwise. One register stage.
// Assumes an even rank count and a unit field narrower than CMP_W.
module rank_addr_decoder
    import rank_addr_pkg::*;
#(
    parameter int RANKS      = DEF_RANKS,
    parameter int BND_W      = DEF_BND_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int UNIT_SHIFT = DEF_UNIT_SHIFT,
    parameter int ILV_BIT    = DEF_ILV_BIT,
    localparam int RIDX_W    = $clog2(RANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RANKS*BND_W-1:0] bnd_ch0,
    input  logic [RANKS*BND_W-1:0] bnd_ch1,
    input  logic [RANKS*NIB_W-1:0] attr_ch0,
    input  logic [RANKS*NIB_W-1:0] attr_ch1,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   rsp_valid,
    output logic [RIDX_W-1:0]      rsp_rank,
    output logic                   rsp_chan,
    output logic                   rsp_oor,
    output logic                   rsp_ilv
);
    localparam int UNIT_W = ADDR_W - UNIT_SHIFT;
    localparam int CMP_W  = BND_W + 2;

    logic                   ilv;
    logic [UNIT_W-1:0]      unit;
    logic [CMP_W-1:0]       ch0_total;
    logic [RANKS*CMP_W-1:0] lim_a, lim_b;
    logic                   hit_a, hit_b, pop_a, pop_b;
    logic [RIDX_W-1:0]      idx_a, idx_b;
    logic [RIDX_W-1:0]      nxt_rank;
    logic                   nxt_chan, nxt_oor;

    assign unit      = req_addr[ADDR_W-1:UNIT_SHIFT];
    assign ch0_total = CMP_W'(bnd_ch0[(RANKS-1)*BND_W +: BND_W]);

    rank_mode_detect #(.RANKS(RANKS), .BND_W(BND_W)) u_mode (
        .bnd0(bnd_ch0), .bnd1(bnd_ch1), .attr0(attr_ch0), .attr1(attr_ch1),
        .interleaved(ilv)
    );

    // Limits: bank A is channel 0 (doubled when interleaved), bank B is
    // channel 1 stacked above channel 0's total.
    for (genvar r = 0; r < RANKS; r++) begin : g_lim
        logic [CMP_W-1:0] raw0;
        assign raw0 = CMP_W'(bnd_ch0[r*BND_W +: BND_W]);
        assign lim_a[r*CMP_W +: CMP_W] = ilv ? (raw0 << 1) : raw0;
        assign lim_b[r*CMP_W +: CMP_W] = ch0_total + CMP_W'(bnd_ch1[r*BND_W +: BND_W]);
    end

    rank_bound_search #(.RANKS(RANKS), .CMP_W(CMP_W), .UNIT_W(UNIT_W)) u_search_a (
        .limits(lim_a), .unit(unit), .hit(hit_a), .idx(idx_a)
    );
    rank_bound_search #(.RANKS(RANKS), .CMP_W(CMP_W), .UNIT_W(UNIT_W)) u_search_b (
        .limits(lim_b), .unit(unit), .hit(hit_b), .idx(idx_b)
    );

    rank_code_fetch #(.RANKS(RANKS)) u_fetch_a (.attr(attr_ch0), .idx(idx_a), .populated(pop_a));
    rank_code_fetch #(.RANKS(RANKS)) u_fetch_b (.attr(attr_ch1), .idx(idx_b), .populated(pop_b));

    // Pick channel 0 span first, then stacked channel 1, else out of range.
    always_comb begin
        nxt_rank = '0;
        nxt_chan = 1'b0;
        nxt_oor  = 1'b1;
        if (hit_a) begin
            nxt_rank = idx_a;
            nxt_chan = ilv & req_addr[ILV_BIT];
            nxt_oor  = !pop_a;
        end else if (hit_b && !ilv) begin
            nxt_rank = idx_b;
            nxt_chan = 1'b1;
            nxt_oor  = !pop_b;
        end
        if (nxt_oor) nxt_rank = '0;
    end

    // Output register stage, captured only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rank  <= '0;
            rsp_chan  <= 1'b0;
            rsp_oor   <= 1'b0;
            rsp_ilv   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_rank <= nxt_rank;
                rsp_chan <= nxt_chan;
                rsp_oor  <= nxt_oor;
                rsp_ilv  <= ilv;
            end
        end
    end

    logic unused_addr;
    assign unused_addr = ^req_addr;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R8
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_oor && !rsp_ilv && rsp_rank == '0));
    // R7
    oor_rank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_oor) |-> rsp_rank == '0);
    // R5
    ilv_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ilv && !rsp_oor) |-> rsp_chan == $past(req_addr[ILV_BIT]));
    // R4
    ilv_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ilv) |-> $past(bnd_ch0 == bnd_ch1));
    // R6
    asym_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ilv && !rsp_oor && !rsp_chan) |->
        $past(CMP_W'(req_addr[ADDR_W-1:UNIT_SHIFT]) < CMP_W'(bnd_ch0[(RANKS-1)*BND_W +: BND_W])));
endmodule

// File: tb/rank_addr_decoder_bench.sv
module rank_addr_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bnd_ch0 = '0, bnd_ch1 = '0;
    logic [15:0] attr_ch0 = '0, attr_ch1 = '0;
    logic        req_valid = 1'b0;
    logic [32:0] req_addr = '0;
    logic        rsp_valid, rsp_chan, rsp_oor, rsp_ilv;
    logic [1:0]  rsp_rank;

    int n_checks = 0;
    int n_errors = 0;
    int b0[4], b1[4], c0[4], c1[4];
    logic [3:0] rsv0 = '0, rsv1 = '0;

    always #2.5 clk = ~clk;

    rank_addr_decoder u_rank_addr_decoder (
        .clk(clk), .rst_n(rst_n), .bnd_ch0(bnd_ch0), .bnd_ch1(bnd_ch1),
        .attr_ch0(attr_ch0), .attr_ch1(attr_ch1), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rank(rsp_rank),
        .rsp_chan(rsp_chan), .rsp_oor(rsp_oor), .rsp_ilv(rsp_ilv)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit legal(input int c);
        return c == 2 || c == 3 || c == 4;
    endfunction

    // Expected {ilv, oor, chan, rank[1:0]} from the requirements.
    function automatic logic [4:0] model(input logic [32:0] a);
        int u = int'(a[32:25]);
        bit ilv = 1, found = 0, pop = 0, chan = 0, oor;
        int rank = 0;
        for (int i = 0; i < 4; i++)
            if (b0[i] != b1[i] || c0[i] != c1[i]) ilv = 0;
        if (ilv) begin
            for (int i = 0; i < 4; i++)
                if (!found && u < 2 * b0[i]) begin
                    found = 1; rank = i; chan = a[6]; pop = legal(c0[i]);
                end
        end else begin
            for (int i = 0; i < 4; i++)
                if (!found && u < b0[i]) begin
                    found = 1; rank = i; chan = 0; pop = legal(c0[i]);
                end
            for (int i = 0; i < 4; i++)
                if (!found && u < b0[3] + b1[i]) begin
                    found = 1; rank = i; chan = 1; pop = legal(c1[i]);
                end
        end
        oor = !found || !pop;
        if (oor) rank = 0;
        return {ilv, oor, chan, 2'(rank)};
    endfunction

    task automatic load_cfg();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            bnd_ch0[i*8 +: 8]  = 8'(b0[i]);
            bnd_ch1[i*8 +: 8]  = 8'(b1[i]);
            attr_ch0[i*4 +: 4] = {rsv0[i], 3'(c0[i])};
            attr_ch1[i*4 +: 4] = {rsv1[i], 3'(c1[i])};
        end
    endtask

    task automatic apply(input string tag, input logic [32:0] a);
        logic [4:0] e;
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        e = model(a);
        check(tag, "rsp_valid", rsp_valid, 1);
        check(tag, "rsp_ilv", rsp_ilv, e[4]);
        check(tag, "rsp_oor", rsp_oor, e[3]);
        check(tag, "rsp_rank", rsp_rank, e[1:0]);
        if (!e[3]) check(tag, "rsp_chan", rsp_chan, e[2]);
    endtask

    function automatic logic [32:0] mk(input int u, input bit b6);
        logic [32:0] a = {8'(u), 25'($urandom)};
        a[6] = b6;
        return a;
    endfunction

    task automatic set4(output int d[4], input int v0, input int v1, input int v2, input int v3);
        d[0] = v0; d[1] = v1; d[2] = v2; d[3] = v3;
    endtask

    initial begin
        #(150000 * 5);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [4:0] held;
        void'($urandom(32'd7351));
        // R9: outputs cleared while in reset, even with a request driven
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "rsp_valid", rsp_valid, 0);
        check("R9", "rsp_oor", rsp_oor, 0);
        check("R9", "rsp_ilv", rsp_ilv, 0);
        req_valid = 1'b0;
        rst_n = 1'b1;

        // R4/R5/R2/R1: symmetric layout with an empty rank 1
        set4(b0, 4, 4, 10, 12); set4(b1, 4, 4, 10, 12);
        set4(c0, 2, 3, 4, 2);   set4(c1, 2, 3, 4, 2);
        load_cfg();
        apply("R4", mk(0, 0));
        apply("R5", mk(7, 1));
        apply("R2", mk(8, 0));
        apply("R1", mk(19, 1));
        apply("R5", mk(20, 0));
        apply("R7", mk(23, 1));
        apply("R7", mk(24, 0));
        // R4: reserved nibble bit differs, still interleaved
        rsv1 = 4'b0101;
        load_cfg();
        apply("R4", mk(3, 1));
        // R4: one code differs, asymmetric
        c1[3] = 3;
        load_cfg();
        apply("R4", mk(3, 1));
        rsv1 = '0;

        // R6/R1/R2: stacked layout
        set4(b0, 2, 2, 5, 6); set4(b1, 1, 3, 3, 8);
        set4(c0, 2, 2, 3, 4); set4(c1, 4, 3, 2, 2);
        load_cfg();
        apply("R1", mk(1, 1));
        apply("R2", mk(2, 0));
        apply("R1", mk(5, 0));
        apply("R6", mk(6, 1));
        apply("R6", mk(7, 0));
        apply("R2", mk(9, 0));
        apply("R6", mk(13, 1));
        apply("R7", mk(14, 0));
        apply("R7", mk(255, 1));
        // R3: reserved and empty codes, odd-rank field position
        c1[1] = 5; c0[0] = 0; c0[3] = 1;
        load_cfg();
        apply("R3", mk(7, 0));
        apply("R3", mk(0, 0));
        apply("R3", mk(5, 0));
        apply("R3", mk(6, 0));
        c0[3] = 7;
        load_cfg();
        apply("R3", mk(5, 1));

        // R8: outputs hold while idle, response valid drops
        apply("R8", mk(6, 0));
        held = model(mk(6, 0));
        req_valid = 1'b0;
        req_addr  = mk(0, 1);
        @(posedge clk);
        @(negedge clk);
        check("R8", "rsp_valid", rsp_valid, 0);
        check("R8", "rsp_rank", rsp_rank, held[1:0]);
        check("R8", "rsp_chan", rsp_chan, held[2]);
        check("R8", "rsp_oor", rsp_oor, held[3]);

        // Random layouts, half of them symmetric
        for (int k = 0; k < 60; k++) begin
            int acc0 = 0, acc1 = 0, lim;
            for (int i = 0; i < 4; i++) begin
                int r0 = int'($urandom % 10);
                int r1 = int'($urandom % 10);
                acc0 += ($urandom % 4 == 0) ? 0 : int'($urandom % 20);
                acc1 += ($urandom % 4 == 0) ? 0 : int'($urandom % 20);
                b0[i] = acc0; b1[i] = acc1;
                c0[i] = (r0 < 6) ? 2 + r0 % 3 : (r0 == 6) ? 0 : (r0 == 7) ? 1 : r0 - 3;
                c1[i] = (r1 < 6) ? 2 + r1 % 3 : (r1 == 6) ? 0 : (r1 == 7) ? 1 : r1 - 3;
            end
            if (k % 2 == 0) begin
                b1 = b0; c1 = c0;
            end
            rsv0 = 4'($urandom); rsv1 = 4'($urandom);
            load_cfg();
            lim = (k % 2 == 0) ? 2 * b0[3] + 3 : b0[3] + b1[3] + 3;
            for (int j = 0; j < 25; j++) begin
                logic [32:0] a = mk(int'($urandom % lim), 1'($urandom));
                logic [4:0] e = model(a);
                apply(e[3] ? "R7" : (e[4] ? "R5" : "R6"), a);
            end
        end

        req_valid = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule